// File: doc/BRIEF.md
# ADC Register Front End

This block sits between a simple synchronous register bus and a multi-channel successive-approximation converter. Software sees four registers. A control register picks the module clock divisor. A result register carries a ready flag and a signed sample. A switch register holds the word that routes the analog multiplexer. A lock register guards the switch register with a one-shot key. Reading the result register does two things. It returns the register's current contents, and if no timed interval is running it asks the converter for a fresh sample. So software issues one read to start a conversion, waits, and reads again to collect the value.

Two timers protect the analog side. One timer enforces the minimum conversion period. The other enforces the settling interval after the multiplexer is rewired. Both count ticks of a prescaled clock, dividing the module clock by 4 or by 16, so the divisor scales the conversion rate and the settling time together. Samples coming back from the converter are saturated to the legal range before they become visible.

Top module: `adc_regfront`

## Requirements
- R1: After reset, the result register reads 0 with the ready flag (bit 31) clear. The control register reads 0, which selects divide-by-16. The lock register reads 0. The switch register reads the `SW_RESET` value. Register byte offsets: control 0x04, result 0x08, switch 0x18, lock 0x20. Unmapped offsets read 0, and all reads return 0 when no read strobe is present.
- R2: A read of the result register while no interval is running returns the register's prior contents. It clears the ready flag, and `conv_req` is high for exactly the one cycle after the read.
- R3: The result register holds the ready flag in bit 31, zeros in bits 30:16 and the sample in bits 15:0. The ready flag sets one cycle after two conditions both hold: the converter has returned a sample since the start, and `CONV_TICKS` prescaler ticks have elapsed.
- R4: A result read while the conversion timer or the settling timer is running does not raise `conv_req` and does not restart a timer. It returns the current contents with bit 31 clear.
- R5: A returned sample above +`LIMIT` (25000) is stored as +25000. A sample below -25000 is stored as -25000. Values within the range are stored unchanged, as 16-bit two's complement.
- R6: A write of exactly 0x000000AA to the lock register opens the lock, and the lock register then reads 1. The next access, if it is a write to the switch register, loads bits 11:0 into the register and onto `sw_cfg` from the following cycle.
- R7: A switch write while the lock is closed leaves the register and `sw_cfg` unchanged. Any bus access other than a valid key write closes the lock, including a read, a write elsewhere, or a key write with any other value.
- R8: An accepted switch write clears the ready flag, abandons any conversion in progress, and starts the settling timer for `SETTLE_TICKS` ticks. A result read issued before the settling timer expires starts nothing.
- R9: Control bit 0 set to 1 selects divide-by-4, and set to 0 selects divide-by-16. The timers advance once per divided period, so a conversion finishes four times sooner with divide-by-4.
- R10: A sample pulse from the converter that arrives while no conversion is outstanding has no effect on the result register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the cycle of the read strobe |
| sw_cfg | output | SW_W | Multiplexer routing word |
| conv_req | output | 1 | One-cycle request for a new sample |
| conv_valid | input | 1 | Converter sample strobe |
| conv_sample | input | SAMPLE_W | Converter sample, two's complement |

## Verification
The hardest state to reach from the ports is a converter sample that arrives after its conversion has already been abandoned. Reaching it takes four steps in a set order: start a conversion, then send the key, then write the switch register while the converter stub still holds a pending sample, then let that sample land. The stimulus builds this sequence so that the late sample lands during settling, and then checks that the stale value never appears. A second hard case is a read that occurs while a timer is still running. The stimulus places reads both inside the conversion window and inside the settling window, under both divisors. A behavioural reference model runs beside the design and is compared with the read data, `sw_cfg` and `conv_req` on every clock.

// File: rtl/adc_regfront.sv
module adc_regfront #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  parameter int SAMPLE_W = 16,
  parameter int SW_W = 12,
  parameter int DIV_FAST = 4,
  parameter int DIV_SLOW = 16,
  parameter int CONV_TICKS = 16,
  parameter int SETTLE_TICKS = 32,
  parameter int LIMIT = 25000,
  parameter logic [SW_W-1:0] SW_RESET = '0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_rd,
  input  logic                bus_wr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic [SW_W-1:0]     sw_cfg,
  output logic                conv_req,
  input  logic                conv_valid,
  input  logic [SAMPLE_W-1:0] conv_sample
);
  localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_RES  = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] A_SW   = ADDR_W'(24);
  localparam logic [ADDR_W-1:0] A_LOCK = ADDR_W'(32);
  localparam logic [DATA_W-1:0] KEY    = DATA_W'(8'hAA);
  localparam int PRE_W = $clog2(DIV_SLOW);
  localparam int TMAX  = (CONV_TICKS > SETTLE_TICKS) ? CONV_TICKS : SETTLE_TICKS;
  localparam int CNT_W = $clog2(TMAX + 1);
  localparam logic signed [SAMPLE_W-1:0] HI = SAMPLE_W'(LIMIT);
  localparam logic signed [SAMPLE_W-1:0] LO = -HI;

  logic [PRE_W-1:0]    pre_q;
  logic [CNT_W-1:0]    conv_cnt, settle_cnt;
  logic                fast_q, lock_open, conv_act, got_q, ready_q;
  logic [SAMPLE_W-1:0] hold_q, res_q;
  logic                tick, busy, settle_busy;
  logic                wr_key, wr_sw, wr_ctl, rd_res, start, finish;
  logic signed [SAMPLE_W-1:0] hold_s, clamped;

  assign tick        = pre_q >= PRE_W'(fast_q ? DIV_FAST - 1 : DIV_SLOW - 1);
  assign settle_busy = settle_cnt != '0;
  assign busy        = settle_busy || (conv_cnt != '0);

  assign wr_key = bus_wr && bus_addr == A_LOCK && bus_wdata == KEY;
  assign wr_sw  = bus_wr && bus_addr == A_SW && lock_open;
  assign wr_ctl = bus_wr && bus_addr == A_CTL;
  assign rd_res = bus_rd && !bus_wr && bus_addr == A_RES;
  assign start  = rd_res && !busy;
  assign finish = conv_act && got_q && conv_cnt == '0 && !start;

  assign hold_s  = signed'(hold_q);
  assign clamped = (hold_s > HI) ? HI : (hold_s < LO) ? LO : hold_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q      <= '0;
      conv_cnt   <= '0;
      settle_cnt <= '0;
      fast_q     <= 1'b0;
      lock_open  <= 1'b0;
      conv_act   <= 1'b0;
      got_q      <= 1'b0;
      ready_q    <= 1'b0;
      hold_q     <= '0;
      res_q      <= '0;
      sw_cfg     <= SW_RESET;
      conv_req   <= 1'b0;
    end else begin
      pre_q    <= tick ? '0 : pre_q + 1'b1;
      conv_req <= start;
      if (bus_rd || bus_wr) lock_open <= wr_key;
      if (wr_ctl) fast_q <= bus_wdata[0];
      if (wr_sw) sw_cfg <= bus_wdata[SW_W-1:0];

      if (wr_sw) settle_cnt <= CNT_W'(SETTLE_TICKS);
      else if (tick && settle_busy) settle_cnt <= settle_cnt - 1'b1;

      if (start) conv_cnt <= CNT_W'(CONV_TICKS);
      else if (wr_sw) conv_cnt <= '0;
      else if (tick && conv_cnt != '0) conv_cnt <= conv_cnt - 1'b1;

      if (start) begin
        conv_act <= 1'b1;
        got_q    <= 1'b0;
        ready_q  <= 1'b0;
      end else if (wr_sw) begin
        conv_act <= 1'b0;
        got_q    <= 1'b0;
        ready_q  <= 1'b0;
      end else if (finish) begin
        conv_act <= 1'b0;
        got_q    <= 1'b0;
        ready_q  <= 1'b1;
        res_q    <= clamped;
      end else if (conv_act && conv_valid) begin
        got_q  <= 1'b1;
        hold_q <= conv_sample;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        A_CTL:   bus_rdata = DATA_W'(fast_q);
        A_RES:   bus_rdata = {ready_q, {(DATA_W-SAMPLE_W-1){1'b0}}, res_q};
        A_SW:    bus_rdata = DATA_W'(sw_cfg);
        A_LOCK:  bus_rdata = DATA_W'(lock_open);
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

module adc_regfront_chk #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  parameter int SAMPLE_W = 16,
  parameter int SW_W = 12,
  parameter int LIMIT = 25000
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [SW_W-1:0]   sw_cfg,
  input logic              conv_req,
  input logic              busy,
  input logic              settle_busy,
  input logic              ready_q,
  input logic              lock_open
);
  localparam logic [ADDR_W-1:0] A_RES  = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] A_SW   = ADDR_W'(24);
  localparam logic [ADDR_W-1:0] A_LOCK = ADDR_W'(32);

  assert_req_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |=> !conv_req);

  assert_busy_no_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && bus_addr == A_RES && busy) |=> !conv_req);

  assert_busy_not_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ready_q);

  assert_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == A_RES) |->
      ($signed(bus_rdata[SAMPLE_W-1:0]) <= LIMIT && $signed(bus_rdata[SAMPLE_W-1:0]) >= -LIMIT));

  assert_sw_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sw_cfg) |-> $past(bus_wr && bus_addr == A_SW && lock_open));

  assert_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_SW && !lock_open) |=> $stable(sw_cfg));

  assert_rearm_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd || (bus_wr && !(bus_addr == A_LOCK && bus_wdata == DATA_W'(8'hAA)))) |=> !lock_open);

  assert_settle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_SW && lock_open) |=> (settle_busy && !ready_q));
endmodule

bind adc_regfront adc_regfront_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SAMPLE_W(SAMPLE_W), .SW_W(SW_W), .LIMIT(LIMIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sw_cfg(sw_cfg), .conv_req(conv_req),
  .busy(busy), .settle_busy(settle_busy), .ready_q(ready_q), .lock_open(lock_open)
);

// File: tb/sim_adc_regfront.sv
module sim_adc_regfront;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int CT = 3;
  localparam int ST = 8;
  localparam int LAT = 4;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [5:0]  bus_addr = 0;
  logic        bus_rd = 0, bus_wr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic [11:0] sw_cfg;
  logic        conv_req;
  logic        conv_valid = 0;
  logic [15:0] conv_sample = 0;

  int n_cmp = 0, n_bad = 0;
  bit run = 0;

  adc_regfront #(.CONV_TICKS(CT), .SETTLE_TICKS(ST), .SW_RESET(12'h608)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sw_cfg(sw_cfg), .conv_req(conv_req),
    .conv_valid(conv_valid), .conv_sample(conv_sample));

  always #10 clk = ~clk;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model, updated on each rising edge
  int m_pre, m_conv, m_settle, m_hold, m_res;
  bit m_fast, m_lock, m_act, m_got, m_ready, m_req;
  int m_sw;

  function automatic int clampv(int raw);
    int v;
    v = (raw >= 32768) ? raw - 65536 : raw;
    if (v > 25000) v = 25000;
    if (v < -25000) v = -25000;
    return v & 16'hFFFF;
  endfunction

  task automatic m_step();
    int div;
    bit tk, busy, key, swr, ctl, rres, st, fin;
    div  = m_fast ? 4 : 16;
    tk   = m_pre >= div - 1;
    busy = (m_conv != 0) || (m_settle != 0);
    key  = bus_wr && bus_addr == 6'h20 && bus_wdata == 32'hAA;
    swr  = bus_wr && bus_addr == 6'h18 && m_lock;
    ctl  = bus_wr && bus_addr == 6'h04;
    rres = bus_rd && !bus_wr && bus_addr == 6'h08;
    st   = rres && !busy;
    fin  = m_act && m_got && m_conv == 0 && !st;
    m_pre = tk ? 0 : m_pre + 1;
    m_req = st;
    if (bus_rd || bus_wr) m_lock = key;
    if (ctl) m_fast = bus_wdata[0];
    if (swr) begin m_sw = int'(bus_wdata[11:0]); m_settle = ST; end
    else if (tk && m_settle > 0) m_settle--;
    if (st) m_conv = CT;
    else if (swr) m_conv = 0;
    else if (tk && m_conv > 0) m_conv--;
    if (st) begin m_act = 1; m_got = 0; m_ready = 0; end
    else if (swr) begin m_act = 0; m_got = 0; m_ready = 0; end
    else if (fin) begin m_act = 0; m_got = 0; m_ready = 1; m_res = clampv(m_hold); end
    else if (m_act && conv_valid) begin m_got = 1; m_hold = int'(conv_sample); end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pre = 0; m_conv = 0; m_settle = 0; m_hold = 0; m_res = 0;
      m_fast = 0; m_lock = 0; m_act = 0; m_got = 0; m_ready = 0; m_req = 0;
      m_sw = 'h608;
    end else m_step();
  end

  function automatic logic [31:0] m_rdata();
    if (!bus_rd) return 32'h0;
    case (bus_addr)
      6'h04: return {31'h0, m_fast};
      6'h08: return {m_ready, 15'h0, m_res[15:0]};
      6'h18: return {20'h0, m_sw[11:0]};
      6'h20: return {31'h0, m_lock};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string rd_tag();
    case (bus_addr)
      6'h04: return "R9";
      6'h08: return "R3";
      6'h18: return "R6";
      6'h20: return "R7";
      default: return "R1";
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n && run) begin
      check(rd_tag(), bus_rdata, m_rdata());
      check("R2", {31'h0, conv_req}, {31'h0, m_req});
      check("R6", {20'h0, sw_cfg}, m_sw);
    end
  end

  // converter stub
  logic [15:0] stub_val = 0;
  bit          spur = 0;
  logic [15:0] spur_val = 0;
  initial begin
    int pend;
    pend = 0;
    forever begin
      @(negedge clk); #1;
      conv_valid = 0;
      if (spur) begin conv_valid = 1; conv_sample = spur_val; spur = 0; end
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin conv_valid = 1; conv_sample = stub_val; end
      end
      if (conv_req) pend = LAT;
    end
  end

  task automatic idle(int n);
    repeat (n) begin @(negedge clk); #1; bus_rd = 0; bus_wr = 0; end
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    @(negedge clk); #1;
    bus_rd = 1; bus_wr = 0; bus_addr = a;
    #2 d = bus_rdata;
    @(negedge clk); #1;
    bus_rd = 0;
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] v);
    @(negedge clk); #1;
    bus_wr = 1; bus_rd = 0; bus_addr = a; bus_wdata = v;
    @(negedge clk); #1;
    bus_wr = 0;
  endtask

  task automatic conv_result(logic [15:0] sv, output logic [31:0] d);
    logic [31:0] junk;
    stub_val = sv;
    rd(6'h08, junk);
    idle(70);
    rd(6'h08, d);
    idle(70);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got hang expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    run = 1;
    idle(2);

    // R1 reset values
    rd(6'h08, d); check("R1 result", d, 32'h0);
    // that read started a conversion; stub returns 0
    idle(70);
    rd(6'h18, d); check("R1 switch", d, 32'h608);
    rd(6'h04, d); check("R1 control", d, 32'h0);
    rd(6'h20, d); check("R1 lock", d, 32'h0);
    rd(6'h3C, d); check("R1 unmapped", d, 32'h0);

    // R2 / R4 start and busy read
    stub_val = 16'd1234;
    rd(6'h08, d); check("R2 prior value", d, 32'h8000_0000);
    check("R2 request", {31'h0, conv_req}, 32'h1);
    rd(6'h08, d); check("R4 busy read", d, 32'h0);
    check("R4 no request", {31'h0, conv_req}, 32'h0);
    idle(70);
    rd(6'h08, d); check("R3 result", d, 32'h8000_04D2);
    idle(70);

    // R5 clamping
    conv_result(16'd30000, d);  check("R5 high clamp", d, 32'h8000_61A8);
    conv_result(-16'sd30000, d); check("R5 low clamp", d, 32'h8000_9E58);
    conv_result(16'd25000, d);  check("R5 high edge", d, 32'h8000_61A8);
    conv_result(16'hFFFF, d);   check("R5 minus one", d, 32'h8000_FFFF);

    // R9 divisor
    wr(6'h04, 32'h1);
    rd(6'h04, d); check("R9 fast select", d, 32'h1);
    stub_val = 16'd77;
    rd(6'h08, d);
    idle(20);
    rd(6'h08, d); check("R9 fast done", d, 32'h8000_004D);
    idle(30);
    wr(6'h04, 32'h0);
    stub_val = 16'd88;
    rd(6'h08, d);
    idle(20);
    rd(6'h08, d); check("R9 slow still busy", d, 32'h0000_004D);
    idle(70);

    // R6 / R7 lock
    wr(6'h18, 32'h680);
    rd(6'h18, d); check("R7 no key", d, 32'h608);
    wr(6'h20, 32'hAA);
    rd(6'h20, d); check("R6 lock open", d, 32'h1);
    wr(6'h18, 32'h680);
    rd(6'h18, d); check("R7 rearm by read", d, 32'h608);
    wr(6'h20, 32'hAA);
    wr(6'h04, 32'h0);
    wr(6'h18, 32'h680);
    rd(6'h18, d); check("R7 rearm by write", d, 32'h608);
    wr(6'h20, 32'hAB);
    rd(6'h20, d); check("R7 wrong key", d, 32'h0);
    wr(6'h20, 32'h1AA);
    rd(6'h20, d); check("R6 exact key", d, 32'h0);
    wr(6'h20, 32'hAA);
    wr(6'h18, 32'h680);
    check("R6 sw_cfg port", {20'h0, sw_cfg}, 32'h680);
    rd(6'h18, d); check("R6 switch loaded", d, 32'h680);

    // R8 settling
    rd(6'h08, d); check("R8 ready cleared", d, 32'h0000_0058);
    check("R8 no start", {31'h0, conv_req}, 32'h0);
    idle(60);
    rd(6'h08, d); check("R8 still settling", d, 32'h0000_0058);
    check("R8 no start late", {31'h0, conv_req}, 32'h0);
    idle(100);
    stub_val = 16'd555;
    rd(6'h08, d); check("R8 after settle", d, 32'h0000_0058);
    check("R8 request", {31'h0, conv_req}, 32'h1);
    idle(70);
    rd(6'h08, d); check("R3 after settle", d, 32'h8000_022B);
    idle(70);

    // R8 abandon in-flight conversion
    stub_val = 16'd999;
    rd(6'h08, d);
    idle(1);
    wr(6'h20, 32'hAA);
    wr(6'h18, 32'h601);
    idle(200);
    rd(6'h08, d); check("R8 abandoned", d, 32'h0000_022B);
    idle(70);

    // R10 stray sample
    spur_val = 16'd4444;
    spur = 1;
    idle(5);
    rd(6'h08, d); check("R10 stray ignored", d, 32'h8000_03E7);
    idle(70);

    run = 0;
    summary();
    $finish;
  end
endmodule